// File: doc/BRIEF.md
# Bus-Mapped Peripheral Register Bank

This block gives an 8-bit processor bus a small window of peripheral registers. It compares the upper address bits with a base-address parameter and, when they match and the request strobe is low, decodes the low address bits to one of eight register slots. The read strobe, write strobe and request strobe are all active low. A parameter chooses whether the memory request or the I/O request qualifies an access. The strobe that is not chosen has no effect.

The slots hold different register kinds:

| Offset | Kind |
|---|---|
| 0 | Read-only status word taken straight from an input |
| 1, 2 | Configuration registers with reset defaults |
| 3 | Flag register that software sets and hardware clears |
| 4 | Receive word. Reading it emits a one-cycle pop pulse. |
| 5 | Transmit register. Writing it stores the byte and emits a one-cycle push pulse. |
| 6, 7 | Not mapped |

The read data and the data-output-enable are combinational. They are built from a priority selection over the read selects, not from tri-state drivers. An interrupt input forces the status slot's read select. While it is high, the status word appears on the read bus with the enable raised, whatever the bus is doing.

Top module: `regbank`

## Requirements
- R1: An access is decoded only when address bits [15:3] equal the base address bits [15:3] (default 0x0040) and the chosen request strobe is low. Otherwise `dataOe` stays 0 and no register changes.
- R2: `dataOe` is 1 exactly when a mapped slot's read select is active. A read select is active when the block is decoded with `rdN` low at that slot's offset, or, for slot 0 only, when `intForce` is high. When several read selects are active, `rdData` shows the lowest offset.
- R3: Reading offset 0 returns the current value of `statusIn` in the same cycle. Writing offset 0 has no effect on any register.
- R4: `cfgCtrl` (offset 1) and `cfgMode` (offset 2) reset to their defaults, 0xA5 and 0x03. A write loads `wrData` at the clock edge. Without a write they hold their value.
- R5: `softFlags` (offset 3) resets to 0. At each edge it becomes (its old value OR the written byte, when written) AND NOT `softClr`. A clear bit therefore wins over a set of the same bit in the same cycle.
- R6: Reading offset 4 returns `rxData`. `rxPop` is 1 for exactly the one cycle after each cycle in which that read select is active.
- R7: Writing offset 5 stores `wrData` in `txData`, which reads back at offset 5. `txPush` is 1 for exactly the one cycle after each cycle in which that write select is active.
- R8: Offsets 6 and 7 are unmapped. Reading them gives `dataOe` = 0, and writing them changes no register.
- R9: With the default `USE_MEM_REQ` = 1, `memReqN` qualifies accesses and `ioReqN` is ignored.
- R10: While `rst` is high at a clock edge, all registers and both pulses return to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Bus address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data; don't-care when `dataOe` is 0 |
| dataOe | output | 1 | Read data is being driven |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| memReqN | input | 1 | Memory request, active low |
| ioReqN | input | 1 | I/O request, active low |
| intForce | input | 1 | Forces the status slot's read select |
| statusIn | input | 8 | Status word shown at offset 0 |
| rxData | input | 8 | Receive word shown at offset 4 |
| rxPop | output | 1 | One-cycle pulse after a read of offset 4 |
| cfgCtrl | output | 8 | Configuration register at offset 1 |
| cfgMode | output | 8 | Configuration register at offset 2 |
| softFlags | output | 8 | Software-set, hardware-clear flags at offset 3 |
| softClr | input | 8 | Hardware clear, one bit per flag |
| txData | output | 8 | Transmit register at offset 5 |
| txPush | output | 1 | One-cycle pulse after a write of offset 5 |

## Verification
The assertions take for granted that the bus inputs are settled around each clock edge. They also assume that a single transfer asserts only one of `rdN` and `wrN`, so that at most one write select is active in any cycle. The stimulus keeps to this by changing every bus input half a period away from the rising edge. Each task drives one strobe at a time for a single cycle and then returns the bus to idle, with all strobes high. This lets each pulse and each held value be sampled in a known cycle.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int DATA_W  = 8;
  localparam int LOCAL_W = 3;
  localparam int SLOTS   = 1 << LOCAL_W;

  // slot offsets; priority of the read mux follows offset order
  localparam int OFF_STATUS = 0;
  localparam int OFF_CTRL   = 1;
  localparam int OFF_MODE   = 2;
  localparam int OFF_SOFT   = 3;
  localparam int OFF_RX     = 4;
  localparam int OFF_TX     = 5;

  // which slots exist, and which of them accept writes
  localparam logic [SLOTS-1:0] MAPPED   = 8'b0011_1111;
  localparam logic [SLOTS-1:0] WRITABLE = 8'b0010_1110;

  typedef struct packed {
    logic [SLOTS-1:0] rdSel;
    logic [SLOTS-1:0] wrSel;
  } selStrobes_t;
endpackage

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
  import regbank_pkg::*;
#(
  parameter int              ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0040,
  parameter bit              USE_MEM_REQ = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              memReqN,
  input  logic              ioReqN,
  input  logic              intForce,
  output selStrobes_t       sel
);
  localparam int TAG_W = ADDR_W - LOCAL_W;
  localparam logic [TAG_W-1:0] BLOCK_TAG = BASE_ADDR[ADDR_W-1:LOCAL_W];

  logic reqActive;
  logic blockSel;
  logic [LOCAL_W-1:0] slotAddr;

  assign reqActive = USE_MEM_REQ ? !memReqN : !ioReqN;
  assign blockSel  = (addr[ADDR_W-1:LOCAL_W] == BLOCK_TAG) && reqActive;
  assign slotAddr  = addr[LOCAL_W-1:0];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (MAPPED[i]) begin : g_map
      logic hit;
      assign hit = blockSel && (slotAddr == LOCAL_W'(i));
      if (i == OFF_STATUS) begin : g_int
        assign sel.rdSel[i] = intForce || (hit && !rdN);
      end else begin : g_noint
        assign sel.rdSel[i] = hit && !rdN;
      end
      if (WRITABLE[i]) begin : g_wr
        assign sel.wrSel[i] = hit && !wrN;
      end else begin : g_nowr
        assign sel.wrSel[i] = 1'b0;
      end
    end else begin : g_unmap
      assign sel.rdSel[i] = 1'b0;
      assign sel.wrSel[i] = 1'b0;
    end
  end

  // R1
  no_sel_outside_block_chk: assert property (@(posedge clk) disable iff (rst)
    (addr[ADDR_W-1:LOCAL_W] != BLOCK_TAG) |-> (sel.wrSel == '0));
  // R2
  rd_sel_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (sel.rdSel != '0) |-> (!rdN || intForce));
  // R8
  one_write_target_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel.wrSel));
endmodule

// File: rtl/regbank_dp.sv
module regbank_dp
  import regbank_pkg::*;
#(
  parameter logic [DATA_W-1:0] CTRL_DEFAULT = 8'hA5,
  parameter logic [DATA_W-1:0] MODE_DEFAULT = 8'h03,
  parameter logic [DATA_W-1:0] SOFT_DEFAULT = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  selStrobes_t       sel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] statusIn,
  input  logic [DATA_W-1:0] rxData,
  input  logic [DATA_W-1:0] softClr,
  output logic [DATA_W-1:0] rdData,
  output logic              dataOe,
  output logic [DATA_W-1:0] cfgCtrl,
  output logic [DATA_W-1:0] cfgMode,
  output logic [DATA_W-1:0] softFlags,
  output logic [DATA_W-1:0] txData,
  output logic              rxPop,
  output logic              txPush
);
  logic [DATA_W-1:0] slotVal [SLOTS];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgCtrl <= CTRL_DEFAULT;
      cfgMode <= MODE_DEFAULT;
      txData  <= '0;
    end else begin
      if (sel.wrSel[OFF_CTRL]) cfgCtrl <= wrData;
      if (sel.wrSel[OFF_MODE]) cfgMode <= wrData;
      if (sel.wrSel[OFF_TX])   txData  <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) softFlags <= SOFT_DEFAULT;
    else     softFlags <= (({DATA_W{sel.wrSel[OFF_SOFT]}} & wrData) | softFlags) & ~softClr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxPop  <= 1'b0;
      txPush <= 1'b0;
    end else begin
      rxPop  <= sel.rdSel[OFF_RX];
      txPush <= sel.wrSel[OFF_TX];
    end
  end

  always_comb begin
    for (int i = 0; i < SLOTS; i++) slotVal[i] = '0;
    slotVal[OFF_STATUS] = statusIn;
    slotVal[OFF_CTRL]   = cfgCtrl;
    slotVal[OFF_MODE]   = cfgMode;
    slotVal[OFF_SOFT]   = softFlags;
    slotVal[OFF_RX]     = rxData;
    slotVal[OFF_TX]     = txData;
  end

  // lowest active offset wins
  always_comb begin
    rdData = 'x;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (sel.rdSel[i]) rdData = slotVal[i];
  end

  assign dataOe = |sel.rdSel;

  // R6
  rx_pop_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
    sel.rdSel[OFF_RX] |=> rxPop);
  // R6
  rx_pop_single_chk: assert property (@(posedge clk) disable iff (rst)
    !sel.rdSel[OFF_RX] |=> !rxPop);
  // R7
  tx_push_follows_write_chk: assert property (@(posedge clk) disable iff (rst)
    sel.wrSel[OFF_TX] |=> (txPush && txData == $past(wrData)));
  // R5
  soft_clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (softClr != '0) |=> ((softFlags & $past(softClr)) == '0));
  // R4
  ctrl_holds_chk: assert property (@(posedge clk) disable iff (rst)
    !sel.wrSel[OFF_CTRL] |=> $stable(cfgCtrl));
endmodule

// File: rtl/regbank.sv
module regbank
  import regbank_pkg::*;
#(
  parameter int                ADDR_W       = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR    = 16'h0040,
  parameter bit                USE_MEM_REQ  = 1'b1,
  parameter logic [7:0]        CTRL_DEFAULT = 8'hA5,
  parameter logic [7:0]        MODE_DEFAULT = 8'h03,
  parameter logic [7:0]        SOFT_DEFAULT = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              dataOe,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              memReqN,
  input  logic              ioReqN,
  input  logic              intForce,
  input  logic [7:0]        statusIn,
  input  logic [7:0]        rxData,
  output logic              rxPop,
  output logic [7:0]        cfgCtrl,
  output logic [7:0]        cfgMode,
  output logic [7:0]        softFlags,
  input  logic [7:0]        softClr,
  output logic [7:0]        txData,
  output logic              txPush
);
  selStrobes_t sel;

  regbank_ctrl #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .USE_MEM_REQ(USE_MEM_REQ)
  ) u_ctrl (
    .clk(clk), .rst(rst), .addr(addr), .rdN(rdN), .wrN(wrN),
    .memReqN(memReqN), .ioReqN(ioReqN), .intForce(intForce), .sel(sel)
  );

  regbank_dp #(
    .CTRL_DEFAULT(CTRL_DEFAULT), .MODE_DEFAULT(MODE_DEFAULT), .SOFT_DEFAULT(SOFT_DEFAULT)
  ) u_dp (
    .clk(clk), .rst(rst), .sel(sel), .wrData(wrData), .statusIn(statusIn),
    .rxData(rxData), .softClr(softClr), .rdData(rdData), .dataOe(dataOe),
    .cfgCtrl(cfgCtrl), .cfgMode(cfgMode), .softFlags(softFlags), .txData(txData),
    .rxPop(rxPop), .txPush(txPush)
  );
endmodule

// File: tb/regbank_tb.sv
`timescale 1ns/1ps
module regbank_tb;
  logic clk = 1'b0;
  logic rst;
  logic [15:0] addr;
  logic [7:0]  wrData, rdData, statusIn, rxData, softClr;
  logic [7:0]  cfgCtrl, cfgMode, softFlags, txData;
  logic dataOe, rdN, wrN, memReqN, ioReqN, intForce, rxPop, txPush;
  int vecs = 0;
  int miss = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  regbank u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wrData(wrData), .rdData(rdData),
    .dataOe(dataOe), .rdN(rdN), .wrN(wrN), .memReqN(memReqN), .ioReqN(ioReqN),
    .intForce(intForce), .statusIn(statusIn), .rxData(rxData), .rxPop(rxPop),
    .cfgCtrl(cfgCtrl), .cfgMode(cfgMode), .softFlags(softFlags), .softClr(softClr),
    .txData(txData), .txPush(txPush)
  );

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    vecs++;
    if (got !== exp) begin
      miss++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    addr = 16'h0000; rdN = 1; wrN = 1; memReqN = 1; ioReqN = 1; wrData = 8'h00;
    #1;
  endtask

  task automatic busWrite(logic [15:0] a, logic [7:0] d, bit viaIo = 0);
    @(negedge clk);
    addr = a; wrData = d; wrN = 0; rdN = 1;
    memReqN = viaIo; ioReqN = !viaIo;
    idle();
  endtask

  task automatic busRead(logic [15:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    addr = a; rdN = 0; wrN = 1; memReqN = 0; ioReqN = 1;
    #1; d = rdData; oe = dataOe;
    idle();
  endtask

  task automatic testReset();
    check("R10 ctrl", cfgCtrl, 8'hA5);
    check("R10 mode", cfgMode, 8'h03);
    check("R10 soft", softFlags, 8'h00);
    check("R10 tx", txData, 8'h00);
    check("R10 pulses", {6'b0, rxPop, txPush}, 8'h00);
    check("R10 oe", {7'b0, dataOe}, 8'h00);
  endtask

  task automatic testConfig();
    logic [7:0] d; logic oe;
    busWrite(16'h0041, 8'h3C);
    check("R4 ctrl write", cfgCtrl, 8'h3C);
    check("R4 mode untouched", cfgMode, 8'h03);
    busWrite(16'h0042, 8'hE1);
    check("R4 mode write", cfgMode, 8'hE1);
    busRead(16'h0041, d, oe);
    check("R2 ctrl readback", d, 8'h3C);
    check("R2 oe on read", {7'b0, oe}, 8'h01);
  endtask

  task automatic testStatus();
    logic [7:0] d; logic oe;
    statusIn = 8'h5A;
    busRead(16'h0040, d, oe);
    check("R3 status read", d, 8'h5A);
    statusIn = 8'hC3;
    busRead(16'h0040, d, oe);
    check("R3 status live", d, 8'hC3);
    busWrite(16'h0040, 8'hFF);
    check("R3 write ignored ctrl", cfgCtrl, 8'h3C);
    check("R3 write ignored soft", softFlags, 8'h00);
  endtask

  task automatic testSoft();
    busWrite(16'h0043, 8'h0F);
    check("R5 set", softFlags, 8'h0F);
    busWrite(16'h0043, 8'h30);
    check("R5 or", softFlags, 8'h3F);
    @(negedge clk); softClr = 8'h03; @(negedge clk); softClr = 8'h00; #1;
    check("R5 hw clear", softFlags, 8'h3C);
    @(negedge clk);
    addr = 16'h0043; wrData = 8'hC0; wrN = 0; memReqN = 0; softClr = 8'h84;
    @(negedge clk); softClr = 8'h00;
    addr = 16'h0000; wrN = 1; memReqN = 1; #1;
    check("R5 clear wins", softFlags, 8'h78);
  endtask

  task automatic testRx();
    logic [7:0] d; logic oe;
    rxData = 8'h96;
    check("R6 pop idle", {7'b0, rxPop}, 8'h00);
    busRead(16'h0044, d, oe);
    check("R6 rx data", d, 8'h96);
    check("R6 pop pulse", {7'b0, rxPop}, 8'h01);
    @(negedge clk); #1;
    check("R6 pop single", {7'b0, rxPop}, 8'h00);
  endtask

  task automatic testTx();
    logic [7:0] d; logic oe;
    busWrite(16'h0045, 8'h6B);
    check("R7 tx stored", txData, 8'h6B);
    check("R7 push pulse", {7'b0, txPush}, 8'h01);
    @(negedge clk); #1;
    check("R7 push single", {7'b0, txPush}, 8'h00);
    busRead(16'h0045, d, oe);
    check("R7 tx readback", d, 8'h6B);
    check("R7 no push on read", {7'b0, txPush}, 8'h00);
  endtask

  task automatic testUnmapped();
    logic [7:0] d; logic oe;
    busRead(16'h0046, d, oe);
    check("R8 oe off6", {7'b0, oe}, 8'h00);
    busRead(16'h0047, d, oe);
    check("R8 oe off7", {7'b0, oe}, 8'h00);
    busWrite(16'h0046, 8'h11);
    busWrite(16'h0047, 8'h22);
    check("R8 ctrl kept", cfgCtrl, 8'h3C);
    check("R8 mode kept", cfgMode, 8'hE1);
    check("R8 soft kept", softFlags, 8'h78);
    check("R8 tx kept", txData, 8'h6B);
    check("R8 no push", {7'b0, txPush}, 8'h00);
  endtask

  task automatic testBlockAndReq();
    logic [7:0] d; logic oe;
    busWrite(16'h0049, 8'h77);
    check("R1 other block", cfgCtrl, 8'h3C);
    busWrite(16'h1041, 8'h77);
    check("R1 high bit differs", cfgCtrl, 8'h3C);
    busRead(16'h0841, d, oe);
    check("R1 oe outside", {7'b0, oe}, 8'h00);
    @(negedge clk);
    addr = 16'h0041; wrData = 8'h77; wrN = 0; memReqN = 1; ioReqN = 1;
    idle();
    check("R1 no request", cfgCtrl, 8'h3C);
    busWrite(16'h0041, 8'h77, 1);
    check("R9 io ignored", cfgCtrl, 8'h3C);
    busWrite(16'h0041, 8'h81);
    check("R9 mem accepted", cfgCtrl, 8'h81);
  endtask

  task automatic testIntForce();
    @(negedge clk);
    statusIn = 8'h4E; intForce = 1; #1;
    check("R2 int oe", {7'b0, dataOe}, 8'h01);
    check("R2 int data", rdData, 8'h4E);
    addr = 16'h0042; rdN = 0; memReqN = 0; #1;
    check("R2 priority", rdData, 8'h4E);
    idle();
    intForce = 0; #1;
    check("R2 oe released", {7'b0, dataOe}, 8'h00);
  endtask

  task automatic testResetAgain();
    busWrite(16'h0043, 8'h01);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0; #1;
    testReset();
  endtask

  initial begin
    #1000000;
    if (!done) begin
      miss++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  initial begin
    rst = 1; addr = 0; wrData = 0; rdN = 1; wrN = 1; memReqN = 1; ioReqN = 1;
    intForce = 0; statusIn = 0; rxData = 0; softClr = 0;
    repeat (3) @(negedge clk);
    rst = 0; #1;
    testReset();
    testConfig();
    testStatus();
    testSoft();
    testRx();
    testTx();
    testUnmapped();
    testBlockAndReq();
    testIntForce();
    testResetAgain();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule